// File: doc/BRIEF.md
# Oversampled asynchronous character receiver

This block turns an asynchronous serial line into characters. It is clocked by the system clock, advances only on a 16x oversampling enable, and finds each character from the falling edge of its start bit. It samples every bit once at the middle of that bit. Each completed character comes out as a one-cycle strobe. The strobe carries the data word and that character's parity, framing and overrun flags.

The character format is taken from a small set of configuration inputs:
- 5 to 8 data bits.
- An optional parity bit: even, odd, or forced to a fixed level.
- A 9-bit mode, in which one extra bit after the data is delivered with the data as an address/data marker.
- One or two stop bits.

The format is captured when a start edge is seen, so a character is always decoded with the format that was in force when it began.

Line conditions are reported as separate one-cycle events. A start bit that has gone high again by its middle is reported as a false start and dropped. A break is an all-zero frame, including any extra bit, with a low stop bit. When the line falls partway through a character, that character ends with a framing error and the break follows on the next frame. A break raises a break-start event. The receiver then accepts nothing more until it samples the line high again, and that first high sample raises a break-end event. Overrun is raised with a character when the downstream `ready_i` is low on the completing cycle. Buffering, interrupt handling and baud generation are left to neighbouring blocks.

Top module: `serial_char_rx`

## Requirements
- R1: While `rst_ni` is low, every event output is low and `data_o` is zero.
- R2: The first enabled sample of a low line (after `SYNC_STAGES` synchroniser flops) starts a character. Bit k (start = 0) is sampled `OS_RATE/2 + k*OS_RATE` enabled ticks later. Every output changes on the clock edge of the sample that decides it.
- R3: `cfg_len_i` encoding: 0→5, 1→6, 2→7, 3→8 data bits. Data is received LSB first into `data_o[0]` upward, and unused upper bits of `data_o` read zero.
- R4: `cfg_par_i` encoding: 0 none, 1 even, 2 odd, 3 forced. Even and odd count the data bits plus the parity bit. Forced parity expects the parity bit to equal `cfg_par_val_i`. A mismatch raises `par_err_o`.
- R5: When `cfg_nine_i` is 1, one extra bit follows the data and is delivered in `data_o[8]`. No parity bit is expected, and `par_err_o` stays low whatever `cfg_par_i` holds.
- R6: A low first stop bit ends the character at once with `frm_err_o`. When `cfg_stop2_i` is 1 and the first stop bit is high, the second stop bit is also sampled, and if it is low `frm_err_o` is raised.
- R7: `ovr_o` is raised with `valid_o` when `ready_i` is low on the completing edge. The character is still delivered.
- R8: A start bit sampled high at its middle produces a `false_start_o` pulse with no character, and the receiver returns to idle.
- R9: A frame whose data and extra bits are all zero and whose first stop bit is low produces `brk_start_o` and no `valid_o`. A single one bit anywhere in the frame makes it an ordinary character instead.
- R10: If the line falls and stays low partway through a character, that character completes with `frm_err_o`, and the frame that follows reports `brk_start_o`.
- R11: After a break, no character or false start is reported until the line is sampled high. That first high sample produces exactly one `brk_end_o` pulse.
- R12: `par_err_o`, `frm_err_o` and `ovr_o` are high only together with `valid_o`, and at most one of `valid_o`, `brk_start_o`, `brk_end_o`, `false_start_o` is high in any cycle.
- R13: Changes to the configuration inputs after a character has started do not affect that character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| os_tick_i | input | 1 | Oversampling enable, 16 per bit time |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len_i | input | 2 | Data bit count code (0→5 … 3→8) |
| cfg_par_i | input | 2 | Parity mode code (none, even, odd, forced) |
| cfg_par_val_i | input | 1 | Expected parity level in forced mode |
| cfg_nine_i | input | 1 | 9-bit mode, extra bit replaces parity |
| cfg_stop2_i | input | 1 | Check two stop bits |
| ready_i | input | 1 | Downstream can accept a character |
| valid_o | output | 1 | One-cycle character strobe |
| data_o | output | 9 | Received character, bit 8 = extra bit |
| par_err_o | output | 1 | Parity mismatch, with `valid_o` |
| frm_err_o | output | 1 | Low stop bit, with `valid_o` |
| ovr_o | output | 1 | Ready was low at completion, with `valid_o` |
| brk_start_o | output | 1 | Break detected |
| brk_end_o | output | 1 | Line high again after a break |
| false_start_o | output | 1 | Start bit rejected |

## Verification
The bench builds the receiver with `OS_RATE` = 16 and `SYNC_STAGES` = 2 and holds the oversampling enable high. One bit time is therefore exactly 16 clocks, and each expected event falls on an edge that can be computed from the cycle where the stimulus changed. Because of this, every output is compared on every clock against a queue of predicted events. A character costs under 200 cycles, so one run can cover all lengths, all parity modes with both good and bad parity bits, 9-bit mode, both stop counts, a false start, breaks that begin at a frame boundary and mid-character, and a configuration change in the middle of a character.

// File: rtl/rx_pkg.sv
package rx_pkg;
  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_EVEN  = 2'd1,
    PAR_ODD   = 2'd2,
    PAR_FORCE = 2'd3
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_EXTRA,
    ST_STOP1,
    ST_STOP2,
    ST_BRK
  } rx_state_e;

  typedef struct packed {
    logic [1:0] len;
    par_mode_e  par;
    logic       par_val;
    logic       nine;
    logic       stop2;
  } rx_cfg_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (STAGES < 2) begin : g_single
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b1;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_chain
      logic [STAGES-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '1;   // line idles high
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
      end
      assign q_o = sr_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/rx_phase_ctr.sv
module rx_phase_ctr #(
  parameter int OS_RATE = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic restart_i,
  output logic mid_o
);
  localparam int CNT_W = $clog2(OS_RATE);
  localparam logic [CNT_W-1:0] MID_C = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] TOP_C = CNT_W'(OS_RATE - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (restart_i || cnt_q == TOP_C) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  // strobe on the tick that is OS_RATE/2 after restart, then every OS_RATE
  assign mid_o = tick_i & ~restart_i & (cnt_q == MID_C);
endmodule

// File: rtl/rx_char_eval.sv
module rx_char_eval
  import rx_pkg::*;
(
  input  logic [1:0] len_i,
  input  par_mode_e  par_i,
  input  logic       par_val_i,
  input  logic       nine_i,
  input  logic       data_xor_i,
  input  logic       ext_bit_i,
  output logic [2:0] last_idx_o,
  output logic       has_ext_o,
  output logic       par_err_o
);
  assign last_idx_o = {1'b1, len_i};   // 4..7
  assign has_ext_o  = nine_i | (par_i != PAR_NONE);

  always_comb begin
    par_err_o = 1'b0;
    if (!nine_i) begin
      case (par_i)
        PAR_EVEN:  par_err_o = data_xor_i ^ ext_bit_i;
        PAR_ODD:   par_err_o = ~(data_xor_i ^ ext_bit_i);
        PAR_FORCE: par_err_o = ext_bit_i ^ par_val_i;
        default:   par_err_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rx_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       line_i,
  input  logic       mid_i,
  input  logic       ready_i,
  input  rx_cfg_t    cfg_i,
  output logic       restart_o,
  output logic       valid_o,
  output logic [8:0] data_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       ovr_o,
  output logic       brk_start_o,
  output logic       brk_end_o,
  output logic       false_start_o
);
  rx_state_e  state_q;
  rx_cfg_t    cfg_q;
  logic [2:0] bidx_q;
  logic [7:0] shr_q;
  logic       xor_q, ones_q, ext_q;
  logic       valid_q, pe_q, fe_q, ov_q, bs_q, be_q, fs_q;
  logic [8:0] data_q;

  logic [2:0] last_idx;
  logic       has_ext, par_err;

  rx_char_eval i_eval (
    .len_i      (cfg_q.len),
    .par_i      (cfg_q.par),
    .par_val_i  (cfg_q.par_val),
    .nine_i     (cfg_q.nine),
    .data_xor_i (xor_q),
    .ext_bit_i  (ext_q),
    .last_idx_o (last_idx),
    .has_ext_o  (has_ext),
    .par_err_o  (par_err)
  );

  assign restart_o = (state_q == ST_IDLE) & tick_i & ~line_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cfg_q   <= '0;
      bidx_q  <= '0;
      shr_q   <= '0;
      xor_q   <= 1'b0;
      ones_q  <= 1'b0;
      ext_q   <= 1'b0;
      valid_q <= 1'b0;
      data_q  <= '0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ov_q    <= 1'b0;
      bs_q    <= 1'b0;
      be_q    <= 1'b0;
      fs_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      pe_q    <= 1'b0;
      fe_q    <= 1'b0;
      ov_q    <= 1'b0;
      bs_q    <= 1'b0;
      be_q    <= 1'b0;
      fs_q    <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (restart_o) begin
            cfg_q   <= cfg_i;   // format frozen per character
            state_q <= ST_START;
          end
        end
        ST_START: begin
          if (mid_i) begin
            if (line_i) begin
              fs_q    <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              bidx_q  <= '0;
              shr_q   <= '0;
              xor_q   <= 1'b0;
              ones_q  <= 1'b0;
              ext_q   <= 1'b0;
              state_q <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (mid_i) begin
            shr_q[bidx_q] <= line_i;
            xor_q         <= xor_q ^ line_i;
            ones_q        <= ones_q | line_i;
            if (bidx_q == last_idx) state_q <= has_ext ? ST_EXTRA : ST_STOP1;
            else                    bidx_q  <= bidx_q + 3'd1;
          end
        end
        ST_EXTRA: begin
          if (mid_i) begin
            ext_q   <= line_i;
            ones_q  <= ones_q | line_i;
            state_q <= ST_STOP1;
          end
        end
        ST_STOP1: begin
          if (mid_i) begin
            if (!line_i && !ones_q) begin
              bs_q    <= 1'b1;
              state_q <= ST_BRK;
            end else if (!line_i || !cfg_q.stop2) begin
              valid_q <= 1'b1;
              data_q  <= {cfg_q.nine & ext_q, shr_q};
              pe_q    <= par_err;
              fe_q    <= ~line_i;
              ov_q    <= ~ready_i;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_STOP2;
            end
          end
        end
        ST_STOP2: begin
          if (mid_i) begin
            valid_q <= 1'b1;
            data_q  <= {cfg_q.nine & ext_q, shr_q};
            pe_q    <= par_err;
            fe_q    <= ~line_i;
            ov_q    <= ~ready_i;
            state_q <= ST_IDLE;
          end
        end
        ST_BRK: begin
          if (tick_i && line_i) begin
            be_q    <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign valid_o       = valid_q;
  assign data_o        = data_q;
  assign par_err_o     = pe_q;
  assign frm_err_o     = fe_q;
  assign ovr_o         = ov_q;
  assign brk_start_o   = bs_q;
  assign brk_end_o     = be_q;
  assign false_start_o = fs_q;

  // R12
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({valid_q, bs_q, be_q, fs_q}));
  // R12
  flag_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pe_q | fe_q | ov_q) |-> valid_q);
  // R7
  ovr_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ov_q |-> !$past(ready_i));
  // R8
  false_start_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_q |-> $past(line_i));
  // R9
  brk_line_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bs_q |-> !$past(line_i));
  // R5
  nine_no_par_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && cfg_q.nine) |-> !pe_q);
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
  import rx_pkg::*;
#(
  parameter int OS_RATE     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       os_tick_i,
  input  logic       rxd_i,
  input  logic [1:0] cfg_len_i,
  input  logic [1:0] cfg_par_i,
  input  logic       cfg_par_val_i,
  input  logic       cfg_nine_i,
  input  logic       cfg_stop2_i,
  input  logic       ready_i,
  output logic       valid_o,
  output logic [8:0] data_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       ovr_o,
  output logic       brk_start_o,
  output logic       brk_end_o,
  output logic       false_start_o
);
  logic    line_s, restart, mid;
  rx_cfg_t cfg_live;

  assign cfg_live = '{len:     cfg_len_i,
                      par:     par_mode_e'(cfg_par_i),
                      par_val: cfg_par_val_i,
                      nine:    cfg_nine_i,
                      stop2:   cfg_stop2_i};

  rx_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (rxd_i),
    .q_o    (line_s)
  );

  rx_phase_ctr #(.OS_RATE(OS_RATE)) i_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (os_tick_i),
    .restart_i (restart),
    .mid_o     (mid)
  );

  rx_frame_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (os_tick_i),
    .line_i        (line_s),
    .mid_i         (mid),
    .ready_i       (ready_i),
    .cfg_i         (cfg_live),
    .restart_o     (restart),
    .valid_o       (valid_o),
    .data_o        (data_o),
    .par_err_o     (par_err_o),
    .frm_err_o     (frm_err_o),
    .ovr_o         (ovr_o),
    .brk_start_o   (brk_start_o),
    .brk_end_o     (brk_end_o),
    .false_start_o (false_start_o)
  );

  // break bracket tracker for the checks below
  logic brk_open_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          brk_open_q <= 1'b0;
    else if (brk_start_o) brk_open_q <= 1'b1;
    else if (brk_end_o)   brk_open_q <= 1'b0;
  end

  // R11
  brk_end_paired_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_end_o |-> brk_open_q);
  // R11
  no_char_in_brk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_open_q |-> !(valid_o || false_start_o || brk_start_o));
endmodule

// File: tb/test_serial_char_rx.sv
module test_serial_char_rx;
  localparam int OS   = 16;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni = 1'b0;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len_i = 2'd3;
  logic [1:0] cfg_par_i = 2'd0;
  logic       cfg_par_val_i = 1'b0;
  logic       cfg_nine_i = 1'b0;
  logic       cfg_stop2_i = 1'b0;
  logic       ready_i = 1'b1;
  logic       valid_o, par_err_o, frm_err_o, ovr_o;
  logic       brk_start_o, brk_end_o, false_start_o;
  logic [8:0] data_o;

  serial_char_rx #(.OS_RATE(OS), .SYNC_STAGES(SYNC)) i_serial_char_rx (
    .clk_i(clk), .rst_ni(rst_ni), .os_tick_i(1'b1), .rxd_i(rxd),
    .cfg_len_i(cfg_len_i), .cfg_par_i(cfg_par_i), .cfg_par_val_i(cfg_par_val_i),
    .cfg_nine_i(cfg_nine_i), .cfg_stop2_i(cfg_stop2_i), .ready_i(ready_i),
    .valid_o(valid_o), .data_o(data_o), .par_err_o(par_err_o),
    .frm_err_o(frm_err_o), .ovr_o(ovr_o), .brk_start_o(brk_start_o),
    .brk_end_o(brk_end_o), .false_start_o(false_start_o)
  );

  typedef struct {
    int         cyc;
    logic [6:0] ev;    // valid, pe, fe, ov, bs, be, fs
    logic [8:0] data;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   vectors = 0;
  int   miscmp = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic exp_t mk(int c, logic v, logic pe, logic fe, logic ov,
                              logic bs, logic be, logic fs, logic [8:0] d, string t);
    exp_t e;
    e.cyc = c; e.ev = {v, pe, fe, ov, bs, be, fs}; e.data = d; e.tag = t;
    return e;
  endfunction

  // reference comparison on every clock
  always @(negedge clk) begin : cmp_blk
    logic [6:0] got;
    exp_t e;
    if (!done) begin
      got = {valid_o, par_err_o, frm_err_o, ovr_o, brk_start_o, brk_end_o, false_start_o};
      vectors++;
      if (q.size() > 0 && q[0].cyc == cyc) begin
        e = q.pop_front();
        if (got !== e.ev || (e.ev[6] && data_o !== e.data)) begin
          miscmp++;
          $display("FAIL %s cyc=%0d got ev=%b data=%h exp ev=%b data=%h",
                   e.tag, cyc, got, data_o, e.ev, e.data);
        end
      end else if (!rst_ni) begin
        if (got !== 7'b0 || data_o !== 9'h0) begin  // R1
          miscmp++;
          $display("FAIL R1 cyc=%0d got ev=%b data=%h exp ev=0 data=0", cyc, got, data_o);
        end
      end else if (got !== 7'b0) begin  // R12 / R11: nothing outside predicted events
        miscmp++;
        $display("FAIL R12 cyc=%0d got ev=%b exp ev=0000000", cyc, got);
      end
    end
  end

  task automatic hold(input logic lv, input int n);
    rxd = lv;
    repeat (n) @(negedge clk);
  endtask

  // one frame: predicts the outcome from the requirements, then drives it
  task automatic frame(input int len, input int par, input logic pv, input logic nine,
                       input logic stop2, input logic [7:0] dat, input logic extb,
                       input logic st_a, input logic st_b, input logic rdy,
                       input logic scramble, input string tag);
    int         c0, d, he, nb, idx, es, n1;
    logic [7:0] m;
    logic       anyone, pe, fe;
    cfg_len_i = 2'(len - 5); cfg_par_i = 2'(par); cfg_par_val_i = pv;
    cfg_nine_i = nine; cfg_stop2_i = stop2; ready_i = rdy;
    c0 = cyc;
    d  = c0 + SYNC + 1;
    he = (nine || par != 0) ? 1 : 0;
    m  = 8'((1 << len) - 1);
    nb = 1 + len + he;
    n1 = $countones(dat & m);
    anyone = ((dat & m) != 8'h0) || (he == 1 && extb);
    pe = 1'b0;
    if (!nine) begin
      case (par)
        1: pe = ((n1 + int'(extb)) % 2) != 0;
        2: pe = ((n1 + int'(extb)) % 2) == 0;
        3: pe = (extb != pv);
        default: pe = 1'b0;
      endcase
    end
    if (!st_a && !anyone) begin
      q.push_back(mk(d + OS/2 + OS*nb, 0, 0, 0, 0, 1, 0, 0, 9'h0, tag));
    end else begin
      idx = (st_a && stop2) ? nb + 1 : nb;
      fe  = st_a ? (stop2 ? !st_b : 1'b0) : 1'b1;
      es  = d + OS/2 + OS*idx;
      q.push_back(mk(es, 1, pe, fe, !rdy, 0, 0, 0, {nine ? extb : 1'b0, dat & m}, tag));
      // line left low: restarts next edge, then rejected by high gap
      if (fe) q.push_back(mk(es + 1 + OS/2, 0, 0, 0, 0, 0, 0, 1, 9'h0, "R8"));
    end
    hold(1'b0, OS);
    if (scramble) begin  // R13: changes after start must not matter
      cfg_len_i = 2'd0; cfg_par_i = 2'd2; cfg_nine_i = 1'b1; cfg_stop2_i = 1'b1;
    end
    for (int i = 0; i < len; i++) hold(dat[i], OS);
    if (he == 1) hold(extb, OS);
    hold(st_a, OS);
    if (stop2) hold(st_b, OS);
    ready_i = 1'b1;
  endtask

  task automatic release_break(input string tag);
    q.push_back(mk(cyc + SYNC + 1, 0, 0, 0, 0, 0, 1, 0, 9'h0, tag));
    hold(1'b1, 3*OS);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset values observed by the comparator during reset
    rst_ni = 1'b1;
    vectors++;
    if (data_o !== 9'h0) begin
      miscmp++;
      $display("FAIL R1 after reset got data=%h exp 000", data_o);
    end
    hold(1'b1, 3*OS);

    // R2 R3: basic 8N1 and lengths, upper bits above length are not sent
    frame(8, 0, 0, 0, 0, 8'hA5, 0, 1, 1, 1, 0, "R2"); hold(1'b1, 3*OS);
    frame(5, 0, 0, 0, 0, 8'hF5, 0, 1, 1, 1, 0, "R3"); hold(1'b1, 3*OS);
    frame(6, 0, 0, 0, 0, 8'hEA, 0, 1, 1, 1, 0, "R3"); hold(1'b1, 3*OS);
    frame(7, 0, 0, 0, 0, 8'h5B, 0, 1, 1, 1, 0, "R3"); hold(1'b1, 3*OS);

    // R4: parity modes, good and bad
    frame(8, 1, 0, 0, 0, 8'h03, 0, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(8, 1, 0, 0, 0, 8'h03, 1, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(7, 2, 0, 0, 0, 8'h07, 0, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(7, 2, 0, 0, 0, 8'h07, 1, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(8, 3, 1, 0, 0, 8'h10, 1, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(8, 3, 1, 0, 0, 8'h10, 0, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);
    frame(6, 3, 0, 0, 0, 8'h21, 1, 1, 1, 1, 0, "R4"); hold(1'b1, 3*OS);

    // R5: nine-bit mode, parity setting ignored
    frame(8, 2, 0, 1, 0, 8'h5A, 1, 1, 1, 1, 0, "R5"); hold(1'b1, 3*OS);
    frame(8, 1, 0, 1, 0, 8'hC3, 0, 1, 1, 1, 0, "R5"); hold(1'b1, 3*OS);

    // R6: stop-bit checks
    frame(8, 0, 0, 0, 0, 8'h81, 0, 0, 1, 1, 0, "R6"); hold(1'b1, 3*OS);
    frame(7, 1, 0, 0, 1, 8'h33, 0, 1, 1, 1, 0, "R6"); hold(1'b1, 3*OS);
    frame(8, 0, 0, 0, 1, 8'h42, 0, 1, 0, 1, 0, "R6"); hold(1'b1, 3*OS);

    // R7: overrun, character still delivered
    frame(8, 0, 0, 0, 0, 8'h99, 0, 1, 1, 0, 0, "R7"); hold(1'b1, 3*OS);

    // R8: short glitch rejected
    begin
      q.push_back(mk(cyc + SYNC + 1 + OS/2, 0, 0, 0, 0, 0, 0, 1, 9'h0, "R8"));
      hold(1'b0, 4);
      hold(1'b1, 3*OS);
    end

    // R9 R11: break on a frame boundary, held long, then released
    frame(8, 0, 0, 0, 0, 8'h00, 0, 0, 0, 1, 0, "R9");
    hold(1'b0, 10*OS);
    release_break("R11");
    // R9: break with parity bit and two stop bits
    frame(6, 1, 0, 0, 1, 8'h00, 0, 0, 0, 1, 0, "R9");
    hold(1'b0, 2*OS);
    release_break("R11");
    // R9: zero data but a one parity bit is an ordinary character
    frame(8, 2, 0, 0, 0, 8'h00, 1, 0, 1, 1, 0, "R9"); hold(1'b1, 3*OS);

    // R10 R11: line falls in the middle of a character
    begin
      int c0, es1;
      cfg_len_i = 2'd3; cfg_par_i = 2'd0; cfg_nine_i = 1'b0; cfg_stop2_i = 1'b0;
      c0  = cyc;
      es1 = c0 + SYNC + 1 + OS/2 + OS*9;
      q.push_back(mk(es1, 1, 0, 1, 0, 0, 0, 0, 9'h00F, "R10"));
      q.push_back(mk(es1 + 1 + OS/2 + OS*9, 0, 0, 0, 0, 1, 0, 0, 9'h0, "R10"));
      hold(1'b0, OS);
      hold(1'b1, 4*OS);
      hold(1'b0, 22*OS);
      release_break("R11");
    end

    // R13: configuration scrambled after the start bit
    frame(8, 1, 0, 0, 0, 8'hC3, 0, 1, 1, 1, 1, "R13"); hold(1'b1, 3*OS);
    frame(8, 1, 0, 0, 0, 8'hC3, 1, 1, 1, 1, 1, "R13"); hold(1'b1, 3*OS);

    hold(1'b1, 4*OS);
    if (q.size() != 0) begin
      miscmp++;
      $display("FAIL %s pending event at cyc=%0d got none exp ev=%b", q[0].tag, q[0].cyc, q[0].ev);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      miscmp++;
      $display("FAIL R12 watchdog got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
    end
  end
endmodule